// File: doc/BRIEF.md
# Circular Audio Loop Streamer

This block moves 16-bit audio words between a sample-processing core and a large word-addressed memory. Two on-chip FIFOs sit on the core side. A prefetch FIFO feeds playback words to the core, and a drain FIFO collects recorded words from the core. Behind them, a reader and a writer each move whole bursts through one shared memory request/acknowledge port. A round-robin arbiter decides which of them gets the port when both want it.

The block keeps three address registers: where the next word is fetched, where the next word is stored, and where the recorded loop ends. The read and write pointers each advance by one per transferred word and wrap freely at the top of the address space. When the core marks the end of a loop, the block drains every word still held in the drain FIFO to memory. It then latches the write address as the loop end and tells the core it may start recording again. From then on, playback returns to address zero each time it reaches the loop end. Both FIFOs and the memory port use the block clock.

Top module: `loop_streamer`

## Requirements
- R1: After reset there is no memory request, busy and startWriter are low, the prefetch FIFO reports empty (inEmpty high, rdEn low), and the drain FIFO accepts words (wrEn high, outFull low).
- R2: The writer raises no memory request while the drain FIFO holds fewer than BURST words (8 by default) and no end-of-loop flush is running.
- R3: Once started, the writer stores words in FIFO order at consecutive addresses from the write pointer, which starts at 0. It moves one word per acknowledge, ends a burst after BURST words or when the FIFO empties, and keeps starting bursts until the FIFO is empty.
- R4: With streamEn high, the reader fetches bursts from consecutive addresses starting at the read pointer (0 after reset). The core sees the words in address order on coreRdData, the head word is visible without a pop, and a pop advances to the next word.
- R5: The reader stops fetching when the prefetch FIFO is full (16 words by default). It issues no read request until occupancy falls to BURST/2 (4) or below. It starts a burst only when the FIFO has room for BURST words.
- R6: An eolReq pulse raises busy in the following cycle. Every word held in the drain FIFO is then written, and the loop end is set to the resulting write pointer. Busy falls, and startWriter is high for exactly the cycle in which busy first reads low.
- R7: wrEn is low while busy is high or the drain FIFO is full. A push while wrEn is low is dropped and never reaches memory.
- R8: After a loop end L has been captured, a fetch from address L-1 is followed by a fetch from address 0, so playback repeats with a period of L words.
- R9: A pointer at the top address (2^ADDR_W - 1) moves to 0 on its next word.
- R10: When the reader and writer both want the port, the grant goes to the side that did not hold the previous burst, so neither starves under concurrent load.
- R11: While memReq is high and memAck is low, memReq, memWe and memAddr hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also used by FIFOs and memory port |
| rstN | input | 1 | Active-low synchronous reset |
| streamEn | input | 1 | Enables playback prefetch |
| coreWrData | input | 16 | Recorded word from the core |
| coreWrPush | input | 1 | Push coreWrData into the drain FIFO |
| coreRdData | output | 16 | Head word of the prefetch FIFO |
| coreRdPop | input | 1 | Consume the head word |
| outFull | output | 1 | Drain FIFO full |
| inEmpty | output | 1 | Prefetch FIFO empty |
| eolReq | input | 1 | One-cycle end-of-loop request |
| busy | output | 1 | End-of-loop flush in progress |
| startWriter | output | 1 | One-cycle pulse: loop end captured, recording may resume |
| rdEn | output | 1 | A playback word is available |
| wrEn | output | 1 | A recorded word may be pushed |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 23 | Word address of the current access |
| memWrData | output | 16 | Write data for the current access |
| memRdData | input | 16 | Read data, valid with memAck on a read |
| memAck | input | 1 | Completes one word of the current access |

## Verification
Busy is due exactly one cycle after eolReq is sampled, and startWriter must be high in the same cycle that busy first reads low. The bench samples both at fixed falling edges. Memory traffic moves at a randomly stalled acknowledge rate, so results that depend on it (stored words, fetch counts, refill after the low mark) are checked only after a settling window. That window is far longer than the worst stall, and the absence of traffic is checked over a similar window. Playback words are compared at every pop against the recorded sequence taken modulo the loop length.

// File: rtl/loop_pkg.sv
package loop_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic rdBeat;   // one fetched word accepted
    logic wrBeat;   // one stored word accepted
    logic capture;  // latch loop end
    logic selWr;    // port address comes from write pointer
  } loop_strobe_t;

  typedef enum logic [1:0] {OWN_NONE, OWN_RD, OWN_WR} owner_e;
  typedef enum logic {EOL_IDLE, EOL_FLUSH} eol_e;
endpackage

// File: rtl/loop_fifo.sv
module loop_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [CW-1:0]    count
);
  localparam int IW = $clog2(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [IW-1:0]    headIdx, tailIdx;
  logic [CW-1:0]    fill;
  logic             doPush, doPop;

  assign doPush   = push && (fill != CW'(DEPTH));
  assign doPop    = pop && (fill != '0);
  assign headData = store[headIdx];
  assign count    = fill;

  always_ff @(posedge clk) begin
    if (doPush) store[tailIdx] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headIdx <= '0;
      tailIdx <= '0;
      fill    <= '0;
    end else begin
      if (doPush) tailIdx <= tailIdx + 1'b1;
      if (doPop)  headIdx <= headIdx + 1'b1;
      fill <= fill + CW'(doPush) - CW'(doPop);
    end
  end
endmodule

// File: rtl/loop_ctrl.sv
module loop_ctrl
  import loop_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int BURST = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         streamEn,
  input  logic         eolReq,
  input  logic         memAck,
  input  logic [CW-1:0] rdCount,
  input  logic [CW-1:0] wrCount,
  output loop_strobe_t strb,
  output logic         memReq,
  output logic         memWe,
  output logic         busy,
  output logic         startWriter
);
  localparam int BW = $clog2(BURST);
  localparam logic [CW-1:0] RD_LOW    = CW'(BURST / 2);
  localparam logic [CW-1:0] WR_HIGH   = CW'(BURST);
  localparam logic [CW-1:0] SPACE_LIM = CW'(DEPTH - BURST);
  localparam logic [CW-1:0] FULL_LVL  = CW'(DEPTH);
  localparam logic [BW-1:0] LAST_BEAT = BW'(BURST - 1);

  owner_e        owner;
  eol_e          eolState;
  logic [BW-1:0] beatCnt;
  logic          lastWr, rdActive, wrActive;
  logic          rdWant, wrWant, flushing, lastBeat;

  assign flushing = (eolState == EOL_FLUSH);
  assign rdWant   = streamEn && rdActive && (rdCount <= SPACE_LIM);
  assign wrWant   = (wrActive || flushing) && (wrCount != '0);
  assign lastBeat = (beatCnt == LAST_BEAT);

  assign memReq       = (owner != OWN_NONE);
  assign memWe        = (owner == OWN_WR);
  assign busy         = flushing;
  assign strb.rdBeat  = memAck && (owner == OWN_RD);
  assign strb.wrBeat  = memAck && (owner == OWN_WR);
  assign strb.selWr   = (owner == OWN_WR);
  assign strb.capture = flushing && (wrCount == '0) && (owner != OWN_WR);

  // Hysteresis flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdActive <= 1'b0;
      wrActive <= 1'b0;
    end else begin
      if (rdCount == FULL_LVL)    rdActive <= 1'b0;
      else if (rdCount <= RD_LOW) rdActive <= 1'b1;
      if (wrCount == '0)           wrActive <= 1'b0;
      else if (wrCount >= WR_HIGH) wrActive <= 1'b1;
    end
  end

  // Port ownership with round-robin grant
  always_ff @(posedge clk) begin
    if (!rstN) begin
      owner   <= OWN_NONE;
      beatCnt <= '0;
      lastWr  <= 1'b0;
    end else begin
      unique case (owner)
        OWN_NONE: begin
          beatCnt <= '0;
          if (rdWant && wrWant) begin
            owner  <= lastWr ? OWN_RD : OWN_WR;
            lastWr <= !lastWr;
          end else if (rdWant) begin
            owner  <= OWN_RD;
            lastWr <= 1'b0;
          end else if (wrWant) begin
            owner  <= OWN_WR;
            lastWr <= 1'b1;
          end
        end
        OWN_RD: if (memAck) begin
          beatCnt <= beatCnt + 1'b1;
          if (lastBeat) owner <= OWN_NONE;
        end
        OWN_WR: if (memAck) begin
          beatCnt <= beatCnt + 1'b1;
          if (lastBeat || wrCount == CW'(1)) owner <= OWN_NONE;
        end
        default: owner <= OWN_NONE;
      endcase
    end
  end

  // End-of-loop marker
  always_ff @(posedge clk) begin
    if (!rstN) begin
      eolState    <= EOL_IDLE;
      startWriter <= 1'b0;
    end else begin
      startWriter <= 1'b0;
      if (!flushing && eolReq) begin
        eolState <= EOL_FLUSH;
      end else if (strb.capture) begin
        eolState    <= EOL_IDLE;
        startWriter <= 1'b1;
      end
    end
  end

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && (memWe == $past(memWe)));
  p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> startWriter);
  p_rr_to_rd_r10: assert property (@(posedge clk) disable iff (!rstN)
    (owner == OWN_NONE) && rdWant && wrWant && lastWr |=> owner == OWN_RD);
  p_rr_to_wr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (owner == OWN_NONE) && rdWant && wrWant && !lastWr |=> owner == OWN_WR);
  p_idle_below_mark_r2: assert property (@(posedge clk) disable iff (!rstN)
    (owner == OWN_NONE) && !flushing && !wrActive && (wrCount < WR_HIGH) |=> owner != OWN_WR);
endmodule

// File: rtl/loop_datapath.sv
module loop_datapath
  import loop_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  loop_strobe_t      strb,
  input  logic              corePush,
  input  logic [DATA_W-1:0] coreWrData,
  input  logic              corePop,
  output logic [DATA_W-1:0] coreRdData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] memWrData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [CW-1:0]     rdCount,
  output logic [CW-1:0]     wrCount
);
  logic [ADDR_W-1:0] rdPtr, wrPtr, eolPtr, rdNext;
  logic              loopSet;

  loop_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) prefetchFifo (
    .clk(clk), .rstN(rstN), .push(strb.rdBeat), .pushData(memRdData),
    .pop(corePop), .headData(coreRdData), .count(rdCount));

  loop_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) drainFifo (
    .clk(clk), .rstN(rstN), .push(corePush), .pushData(coreWrData),
    .pop(strb.wrBeat), .headData(memWrData), .count(wrCount));

  assign rdNext  = rdPtr + 1'b1;
  assign memAddr = strb.selWr ? wrPtr : rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr   <= '0;
      wrPtr   <= '0;
      eolPtr  <= '0;
      loopSet <= 1'b0;
    end else begin
      if (strb.rdBeat) rdPtr <= (loopSet && rdNext == eolPtr) ? '0 : rdNext;
      if (strb.wrBeat) wrPtr <= wrPtr + 1'b1;
      if (strb.capture) begin
        eolPtr  <= wrPtr;
        loopSet <= 1'b1;
      end
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdBeat |-> rdCount < CW'(DEPTH));
  p_pop_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrBeat |-> wrCount != '0);
  p_flush_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> wrCount == '0);
endmodule

// File: rtl/loop_streamer.sv
module loop_streamer
  import loop_pkg::*;
#(
  parameter int ADDR_W     = 23,
  parameter int DATA_W     = 16,
  parameter int BURST      = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              streamEn,
  input  logic [DATA_W-1:0] coreWrData,
  input  logic              coreWrPush,
  output logic [DATA_W-1:0] coreRdData,
  input  logic              coreRdPop,
  output logic              outFull,
  output logic              inEmpty,
  input  logic              eolReq,
  output logic              busy,
  output logic              startWriter,
  output logic              rdEn,
  output logic              wrEn,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              memAck
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  loop_strobe_t  strb;
  logic [CW-1:0] rdCount, wrCount;

  assign outFull = (wrCount == CW'(FIFO_DEPTH));
  assign inEmpty = (rdCount == '0);
  assign rdEn    = !inEmpty;
  assign wrEn    = !outFull && !busy;

  loop_ctrl #(.DEPTH(FIFO_DEPTH), .BURST(BURST)) ctrlU (
    .clk(clk), .rstN(rstN), .streamEn(streamEn), .eolReq(eolReq),
    .memAck(memAck), .rdCount(rdCount), .wrCount(wrCount), .strb(strb),
    .memReq(memReq), .memWe(memWe), .busy(busy), .startWriter(startWriter));

  loop_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) dpU (
    .clk(clk), .rstN(rstN), .strb(strb),
    .corePush(coreWrPush && wrEn), .coreWrData(coreWrData),
    .corePop(coreRdPop && rdEn), .coreRdData(coreRdData),
    .memRdData(memRdData), .memWrData(memWrData), .memAddr(memAddr),
    .rdCount(rdCount), .wrCount(wrCount));

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr));
  p_busy_blocks_push_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !wrEn);
endmodule

// File: tb/loop_streamer_tb_top.sv
module loop_mem_model #(parameter int AW = 23) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  output logic          ack
);
  logic [15:0] store [int];
  int nRd = 0;
  int nWr = 0;

  function automatic logic [15:0] peek(input int a);
    return store.exists(a) ? store[a] : 16'h0000;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      ack   <= 1'b0;
      rdata <= 16'h0;
    end else begin
      ack   <= req && !ack && ($urandom_range(3, 0) != 0);
      rdata <= peek(int'(addr));
      if (req && ack) begin
        if (we) begin
          store[int'(addr)] = wdata;
          nWr++;
        end else begin
          nRd++;
        end
      end
    end
  end
endmodule

module loop_streamer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = !clk;

  int checks = 0;
  int errors = 0;
  logic [15:0] wv [64];

  // Instance under main test
  logic aStream = 0, aPush = 0, aPop = 0, aEol = 0;
  logic [15:0] aWrData = 0, aRdData, aMemWd, aMemRd;
  logic aOutFull, aInEmpty, aBusy, aStart, aRdEn, aWrEn, aReq, aWe, aAck;
  logic [22:0] aAddr;

  loop_streamer dut_i (
    .clk(clk), .rstN(rstN), .streamEn(aStream), .coreWrData(aWrData),
    .coreWrPush(aPush), .coreRdData(aRdData), .coreRdPop(aPop),
    .outFull(aOutFull), .inEmpty(aInEmpty), .eolReq(aEol), .busy(aBusy),
    .startWriter(aStart), .rdEn(aRdEn), .wrEn(aWrEn), .memReq(aReq),
    .memWe(aWe), .memAddr(aAddr), .memWrData(aMemWd), .memRdData(aMemRd),
    .memAck(aAck));
  loop_mem_model #(.AW(23)) memA (
    .clk(clk), .rstN(rstN), .req(aReq), .we(aWe), .addr(aAddr),
    .wdata(aMemWd), .rdata(aMemRd), .ack(aAck));

  // Narrow-address instance for the wrap check
  logic bPush = 0, bEol = 0;
  logic [15:0] bWrData = 0, bRdData, bMemWd, bMemRd;
  logic bOutFull, bInEmpty, bBusy, bStart, bRdEn, bWrEn, bReq, bWe, bAck;
  logic [4:0] bAddr;

  loop_streamer #(.ADDR_W(5)) dutw_i (
    .clk(clk), .rstN(rstN), .streamEn(1'b0), .coreWrData(bWrData),
    .coreWrPush(bPush), .coreRdData(bRdData), .coreRdPop(1'b0),
    .outFull(bOutFull), .inEmpty(bInEmpty), .eolReq(bEol), .busy(bBusy),
    .startWriter(bStart), .rdEn(bRdEn), .wrEn(bWrEn), .memReq(bReq),
    .memWe(bWe), .memAddr(bAddr), .memWrData(bMemWd), .memRdData(bMemRd),
    .memAck(bAck));
  loop_mem_model #(.AW(5)) memB (
    .clk(clk), .rstN(rstN), .req(bReq), .we(bWe), .addr(bAddr),
    .wdata(bMemWd), .rdata(bMemRd), .ack(bAck));

  function automatic logic [15:0] wrapWord(input int k);
    return 16'h5000 + 16'(k);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushA(input logic [15:0] d);
    for (int n = 0; n < 500 && !aWrEn; n++) @(negedge clk);
    aPush = 1'b1; aWrData = d;
    @(negedge clk);
    aPush = 1'b0;
  endtask

  task automatic pushB(input logic [15:0] d);
    for (int n = 0; n < 500 && !bWrEn; n++) @(negedge clk);
    bPush = 1'b1; bWrData = d;
    @(negedge clk);
    bPush = 1'b0;
  endtask

  task automatic popA(input logic [15:0] exp, input string tag);
    for (int n = 0; n < 500 && !aRdEn; n++) @(negedge clk);
    check(aRdEn && aRdData == exp, tag, aRdData, exp);
    aPop = 1'b1;
    @(negedge clk);
    aPop = 1'b0;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int popIdx;
    int rdBefore;
    int wrBefore;
    bit sawStart;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 64; k++) wv[k] = 16'($urandom);
    cyc(4);
    rstN = 1'b1;
    cyc(1);

    // R1 reset state
    check(!aReq && !aBusy && !aStart, "R1 idle port/busy", {aReq, aBusy, aStart}, 0);
    check(aInEmpty && !aRdEn, "R1 prefetch empty", {aInEmpty, aRdEn}, 2);
    check(aWrEn && !aOutFull, "R1 drain accepts", {aWrEn, aOutFull}, 2);

    // R2 below the write mark: no traffic
    for (int k = 0; k < 7; k++) pushA(wv[k]);
    cyc(30);
    check(memA.nWr == 0, "R2 no write below mark", memA.nWr, 0);
    pushA(wv[7]);
    cyc(60);
    check(memA.nWr == 8, "R3 burst of eight stored", memA.nWr, 8);
    for (int k = 0; k < 8; k++)
      check(memA.peek(k) == wv[k], "R3 stored word", memA.peek(k), wv[k]);

    // R6 end-of-loop flush of three leftover words
    for (int k = 8; k < 11; k++) pushA(wv[k]);
    cyc(30);
    check(memA.nWr == 8, "R2 leftover held", memA.nWr, 8);
    aEol = 1'b1;
    @(negedge clk);
    aEol = 1'b0;
    check(aBusy == 1'b1, "R6 busy next cycle", aBusy, 1);
    check(aWrEn == 1'b0, "R7 wrEn low while busy", aWrEn, 0);
    aPush = 1'b1; aWrData = 16'hDEAD;   // R7 dropped push
    @(negedge clk);
    aPush = 1'b0;
    sawStart = 1'b0;
    for (int n = 0; n < 300 && aBusy; n++) begin
      @(negedge clk);
      if (!aBusy) sawStart = aStart;
    end
    check(!aBusy && sawStart, "R6 startWriter as busy falls", sawStart, 1);
    @(negedge clk);
    check(!aStart, "R6 startWriter single cycle", aStart, 0);
    check(memA.nWr == 11, "R6 flush wrote all", memA.nWr, 11);
    for (int k = 8; k < 11; k++)
      check(memA.peek(k) == wv[k], "R6 flushed word", memA.peek(k), wv[k]);

    // R7 dropped word never reaches memory
    for (int k = 11; k < 19; k++) pushA(wv[k]);
    cyc(60);
    check(memA.nWr == 19, "R7 write count", memA.nWr, 19);
    for (int k = 11; k < 19; k++)
      check(memA.peek(k) == wv[k], "R7 word order after drop", memA.peek(k), wv[k]);

    // R4/R5 prefetch fill and hysteresis
    aStream = 1'b1;
    cyc(100);
    check(memA.nRd == 16 && !aInEmpty, "R5 fills to full", memA.nRd, 16);
    cyc(40);
    check(memA.nRd == 16, "R5 no fetch while full", memA.nRd, 16);
    popIdx = 0;
    for (int k = 0; k < 11; k++) begin
      popA(wv[popIdx % 11], "R4 fetched word order");
      popIdx++;
    end
    cyc(40);
    check(memA.nRd == 16, "R5 holds above low mark", memA.nRd, 16);
    popA(wv[popIdx % 11], "R8 loop restart word");
    popIdx++;
    cyc(60);
    check(memA.nRd == 24, "R5 resumes at low mark", memA.nRd, 24);
    for (int k = 0; k < 40; k++) begin
      popA(wv[popIdx % 11], "R8 loop period");
      popIdx++;
      cyc($urandom_range(2, 0));
    end

    // R10 concurrent record and playback
    rdBefore = memA.nRd;
    wrBefore = memA.nWr;
    fork
      begin
        for (int k = 0; k < 60; k++) begin
          popA(wv[popIdx % 11], "R10 playback under load");
          popIdx++;
          cyc($urandom_range(1, 0));
        end
      end
      begin
        for (int k = 19; k < 43; k++) pushA(wv[k]);
      end
    join
    cyc(100);
    check(memA.nWr == wrBefore + 24, "R10 writer progressed", memA.nWr - wrBefore, 24);
    check(memA.nRd > rdBefore + 40, "R10 reader progressed", memA.nRd - rdBefore, 41);
    for (int k = 19; k < 43; k += 5)
      check(memA.peek(k) == wv[k], "R10 stored word", memA.peek(k), wv[k]);

    // R9 wrap on a 32-word address space
    for (int k = 0; k < 40; k++) pushB(wrapWord(k));
    bEol = 1'b1;
    @(negedge clk);
    bEol = 1'b0;
    for (int n = 0; n < 400 && bBusy; n++) @(negedge clk);
    check(!bBusy && memB.nWr == 40, "R9 all words stored", memB.nWr, 40);
    for (int a = 0; a < 8; a++)
      check(memB.peek(a) == wrapWord(a + 32), "R9 wrapped address", memB.peek(a), wrapWord(a + 32));
    check(memB.peek(8) == wrapWord(8), "R9 untouched after wrap", memB.peek(8), wrapWord(8));
    check(memB.peek(31) == wrapWord(31), "R9 top address", memB.peek(31), wrapWord(31));

    finishRun();
  end
endmodule